// File: doc/BRIEF.md
# Seven-Level Drifting-Carrier PWM Modulator

This block produces the six gate signals of one leg of a two-cell seven-level U-cell converter. A signed modulating reference selects an output level from -3 to +3. The reference magnitude is compared against three level-shifted triangular carriers, one for each boundary between adjacent positive levels. The sign of the reference then mirrors the result onto the negative half. The chosen level maps onto three upper switch gates, and the three partner gates are driven with their complements.

A signed drift command, normally produced by an external regulator of the auxiliary capacitor voltage, moves the carriers. The boundary between levels 1 and 2 moves one way and the other two boundaries move the opposite way. This trades dwell time between level 1 (which charges the auxiliary capacitor) and level 2 (which discharges it) without changing the average output much. The two redundant zero-level switch patterns alternate, so that conduction losses are shared across the switches.

Reference and drift are captured once per carrier period, at the carrier peak. A `sync_o` strobe marks that cycle so an upstream controller can align its updates to it.

Top module: `pwm7_drift_mod`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `state_o` is 0, `gate_o` is 3'b000, `gate_n_o` is 3'b111 and `sync_o` is 0. The carrier counter restarts from 0.
- R2: The carrier counts 0,1,...,BAND-1,...,1,0,... with a period of 2*(BAND-1) clocks. `sync_o` is high in the cycle the count equals BAND-1, which is BAND-1 cycles after reset release. `ref_i` and `drift_i` are captured only at the clock edge that ends a `sync_o` cycle. Values held at any other edge have no effect.
- R3: With captured reference r > 0 and drift 0, the level is the number of carriers k in {0,1,2} for which |r| > k*BAND + count. A reference of 0 gives level 0.
- R4: With captured drift d, the carrier between levels 1 and 2 is raised by d. The carriers between levels 0 and 1 and between levels 2 and 3 are lowered by d.
- R5: The drift is limited to the range -DRIFT_LIM..+DRIFT_LIM at capture. A larger magnitude acts as the limit with the same sign.
- R6: A negative reference gives the negated level of its magnitude under the same drift rule.
- R7: The gate encoding gate_o = {T1,T2,T3} is: +1 -> 001, +2 -> 010, +3 -> 011, -1 -> 110, -2 -> 101, -3 -> 100. Level 0 is 000 or 111. `state_o` is the level in two's complement.
- R8: `gate_n_o` is the bitwise complement of `gate_o` in every cycle.
- R9: The zero pattern is 000 from reset. It flips between 000 and 111 each time level 0 is entered from a non-zero level, and stays fixed while the level remains 0.
- R10: `state_o`, `gate_o` and `gate_n_o` are registered and change only on a clock edge, one cycle after the count they were computed from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | REF_W | Signed modulating reference, full scale ±3*BAND |
| drift_i | input | DRIFT_W | Signed carrier drift command |
| sync_o | output | 1 | High in the carrier peak cycle, when inputs are captured |
| state_o | output | 3 | Selected output level, signed -3..+3 |
| gate_o | output | 3 | Upper gates {T1,T2,T3} |
| gate_n_o | output | 3 | Complementary gates {T1',T2',T3'} |

## Verification
The bench measures level dwell counts over whole carrier periods and compares them against counts derived from the carrier and drift rule. A drift applied with the wrong sign to any carrier, or no drift at all, moves cycles between levels 1 and 2 and shows up as a wrong count. Drift commands above the limit check the clamp, because an unclamped drift would let level 2 vanish. Negative references check the mirror rule. Inputs are scrambled in every non-peak cycle; a design that sampled them outside the peak would pick up the scrambled values and show wrong counts. Repeated zero entries check that the zero pattern alternates, which a design that toggled on every zero cycle or never toggled would fail.

// File: rtl/pwm7_pkg.sv
package pwm7_pkg;

  typedef logic signed [2:0] lvl_t;

  // {T1,T2,T3}; zero level picks 000 or 111 by zsel
  function automatic logic [2:0] gate_pattern(lvl_t s, logic zsel);
    logic [2:0] g;
    case (3'(s))
      3'b001:  g = 3'b001;
      3'b010:  g = 3'b010;
      3'b011:  g = 3'b011;
      3'b111:  g = 3'b110;
      3'b110:  g = 3'b101;
      3'b101:  g = 3'b100;
      default: g = {3{zsel}};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pwm7_carrier.sv
module pwm7_carrier #(
  parameter int unsigned BAND  = 256,
  parameter int unsigned CNT_W = $clog2(BAND)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             peak_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(BAND - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q + 1'b1 == TOP) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) up_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign peak_o = (cnt_q == TOP);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);

  p_cnt_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) ||
             (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/pwm7_compare.sv
module pwm7_compare import pwm7_pkg::*; #(
  parameter int unsigned BAND      = 256,
  parameter int unsigned CNT_W     = $clog2(BAND),
  parameter int unsigned REF_W     = 12,
  parameter int unsigned DRIFT_W   = 8,
  parameter int unsigned DRIFT_LIM = 100
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      peak_i,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic signed [REF_W-1:0]   ref_i,
  input  logic signed [DRIFT_W-1:0] drift_i,
  output lvl_t                      lvl_o
);
  localparam int unsigned CMP_W = REF_W + 2;
  localparam logic signed [DRIFT_W-1:0] LIM_P = DRIFT_W'(DRIFT_LIM);
  localparam logic signed [DRIFT_W-1:0] LIM_N = -LIM_P;

  logic signed [REF_W-1:0]   ref_q;
  logic signed [DRIFT_W-1:0] drift_q, drift_c;

  always_comb begin
    if (drift_i > LIM_P)      drift_c = LIM_P;
    else if (drift_i < LIM_N) drift_c = LIM_N;
    else                      drift_c = drift_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      drift_q <= '0;
    end else if (peak_i) begin
      ref_q   <= ref_i;
      drift_q <= drift_c;
    end
  end

  logic signed [CMP_W-1:0] ref_ext, mag, cnt_ext, drift_ext;
  logic [2:0] hit;
  logic [1:0] n_hit;

  assign ref_ext   = {{(CMP_W-REF_W){ref_q[REF_W-1]}}, ref_q};
  assign mag       = ref_q[REF_W-1] ? -ref_ext : ref_ext;
  assign cnt_ext   = $signed({{(CMP_W-CNT_W){1'b0}}, cnt_i});
  assign drift_ext = {{(CMP_W-DRIFT_W){drift_q[DRIFT_W-1]}}, drift_q};

  for (genvar k = 0; k < 3; k++) begin : g_car
    localparam logic signed [CMP_W-1:0] OFS = CMP_W'(k * BAND);
    logic signed [CMP_W-1:0] thr;
    if (k == 1) begin : g_up
      assign thr = OFS + cnt_ext + drift_ext;
    end else begin : g_dn
      assign thr = OFS + cnt_ext - drift_ext;
    end
    assign hit[k] = mag > thr;
  end

  assign n_hit = 2'($countones(hit));

  always_comb begin
    if (ref_q == '0)             lvl_o = '0;
    else if (ref_q[REF_W-1])     lvl_o = -$signed({1'b0, n_hit});
    else                         lvl_o = $signed({1'b0, n_hit});
  end

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peak_i |=> $stable(ref_q) && $stable(drift_q));

  p_drift_lim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drift_q <= LIM_P) && (drift_q >= LIM_N));

  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_q[REF_W-1] |-> !(lvl_o > 0));

endmodule

// File: rtl/pwm7_gate.sv
module pwm7_gate import pwm7_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lvl_t       lvl_i,
  output lvl_t       state_o,
  output logic [2:0] gate_o,
  output logic [2:0] gate_n_o
);
  lvl_t       state_q;
  logic       zsel_q, zsel_d;
  logic [2:0] t_q, tn_q, enc;

  // flip zero pattern on each entry into level 0
  assign zsel_d = (lvl_i == '0 && state_q != '0) ? ~zsel_q : zsel_q;
  assign enc    = gate_pattern(lvl_i, zsel_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      zsel_q  <= 1'b0;
      t_q     <= 3'b000;
      tn_q    <= 3'b111;
    end else begin
      state_q <= lvl_i;
      zsel_q  <= zsel_d;
      t_q     <= enc;
      tn_q    <= ~enc;
    end
  end

  assign state_o  = state_q;
  assign gate_o   = t_q;
  assign gate_n_o = tn_q;

  p_compl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t_q ^ tn_q) == 3'b111);

  p_zero_pat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == '0) |-> (t_q == 3'b000 || t_q == 3'b111));

  p_zero_flip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0 && state_q != '0) |=> (zsel_q != $past(zsel_q)));

  p_zero_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0 && state_q == '0) |=> $stable(t_q));

  p_no_m4_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    3'(state_q) != 3'b100);

endmodule

// File: rtl/pwm7_drift_mod.sv
module pwm7_drift_mod import pwm7_pkg::*; #(
  parameter int unsigned BAND      = 256,
  parameter int unsigned REF_W     = 12,
  parameter int unsigned DRIFT_W   = 8,
  parameter int unsigned DRIFT_LIM = 100
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic signed [REF_W-1:0]   ref_i,
  input  logic signed [DRIFT_W-1:0] drift_i,
  output logic                      sync_o,
  output logic signed [2:0]         state_o,
  output logic [2:0]                gate_o,
  output logic [2:0]                gate_n_o
);
  localparam int unsigned CNT_W = $clog2(BAND);

  logic [CNT_W-1:0] cnt;
  logic             peak;
  lvl_t             lvl, state;

  pwm7_carrier #(.BAND(BAND), .CNT_W(CNT_W)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt),
    .peak_o (peak)
  );

  pwm7_compare #(
    .BAND(BAND), .CNT_W(CNT_W), .REF_W(REF_W),
    .DRIFT_W(DRIFT_W), .DRIFT_LIM(DRIFT_LIM)
  ) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .peak_i  (peak),
    .cnt_i   (cnt),
    .ref_i   (ref_i),
    .drift_i (drift_i),
    .lvl_o   (lvl)
  );

  pwm7_gate u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .state_o  (state),
    .gate_o   (gate_o),
    .gate_n_o (gate_n_o)
  );

  assign sync_o  = peak;
  assign state_o = state;

  p_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (state == $past(lvl)));

endmodule

// File: tb/tb_pwm7_drift_mod.sv
module tb_pwm7_drift_mod;
  localparam int BAND = 8, REF_W = 8, DRIFT_W = 5, LIM = 3;
  localparam int TOP = BAND - 1, PER = 2 * TOP;
  localparam int NV = 14;
  localparam int VREF [NV] = '{0, 4, 12, 20, 24, 30, 12, 12, 12, -12, -20, -4, 9, -30};
  localparam int VDRF [NV] = '{0, 0, 0,  0,  0,  0,  2, -2, 7,  2,   -3,  0, 3, -9};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni;
  logic signed [REF_W-1:0] ref_i;
  logic signed [DRIFT_W-1:0] drift_i;
  logic sync_o;
  logic signed [2:0] state_o;
  logic [2:0] gate_o, gate_n_o;

  pwm7_drift_mod #(.BAND(BAND), .REF_W(REF_W), .DRIFT_W(DRIFT_W), .DRIFT_LIM(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .drift_i(drift_i),
    .sync_o(sync_o), .state_o(state_o), .gate_o(gate_o), .gate_n_o(gate_n_o)
  );

  int n_chk = 0, n_fail = 0;
  int cnt [7];
  bit enc_ok, cmp_ok;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clampd(int d);
    return (d > LIM) ? LIM : (d < -LIM) ? -LIM : d;
  endfunction

  // dwell cycles of level lv per carrier period, from R3..R6
  function automatic int exp_cnt(int r, int d, int lv);
    int dd = clampd(d);
    int m = (r < 0) ? -r : r;
    int tot = 0;
    for (int t = 0; t <= TOP; t++) begin
      int w = (t == 0 || t == TOP) ? 1 : 2;
      int l = int'(m > t - dd) + int'(m > BAND + t + dd) + int'(m > 2 * BAND + t - dd);
      if (r < 0) l = -l;
      if (r == 0) l = 0;
      if (l == lv) tot += w;
    end
    return tot;
  endfunction

  function automatic logic [2:0] exp_gate(int s);
    case (s)
      1: return 3'b001;
      2: return 3'b010;
      3: return 3'b011;
      -1: return 3'b110;
      -2: return 3'b101;
      -3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic apply(int r, int d);
    @(negedge clk);
    while (!sync_o) @(negedge clk);
    ref_i = REF_W'(r);
    drift_i = DRIFT_W'(d);
    repeat (2 * PER) @(negedge clk);
  endtask

  // one carrier period; optional scrambling of inputs outside the peak cycle
  task automatic measure(int r, int d, bit scramble);
    for (int i = 0; i < 7; i++) cnt[i] = 0;
    enc_ok = 1'b1;
    cmp_ok = 1'b1;
    for (int i = 0; i < PER; i++) begin
      int s;
      @(negedge clk);
      s = int'(state_o);
      cnt[s + 3]++;
      if (s != 0 && gate_o != exp_gate(s)) enc_ok = 1'b0;
      if (s == 0 && gate_o != 3'b000 && gate_o != 3'b111) enc_ok = 1'b0;
      if (gate_n_o != ~gate_o) cmp_ok = 1'b0;
      if (scramble) begin
        if (!sync_o) begin
          ref_i = REF_W'(-r + 5);
          drift_i = DRIFT_W'(-d - 1);
        end else begin
          ref_i = REF_W'(r);
          drift_i = DRIFT_W'(d);
        end
      end
    end
    ref_i = REF_W'(r);
    drift_i = DRIFT_W'(d);
  endtask

  task automatic check_counts(int r, int d, string req);
    for (int lv = -3; lv <= 3; lv++)
      check(cnt[lv + 3] == exp_cnt(r, d, lv), req,
            $sformatf("dwell lvl %0d ref %0d drift %0d", lv, r, d),
            cnt[lv + 3], exp_cnt(r, d, lv));
    check(enc_ok, "R7", $sformatf("gate encoding ref %0d", r), int'(enc_ok), 1);
    check(cmp_ok, "R8", $sformatf("complement ref %0d", r), int'(cmp_ok), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k, last_z, prev, eps;
    rst_ni = 1'b0;
    ref_i = '0;
    drift_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(state_o == 0, "R1", "state in reset", int'(state_o), 0);
    check(gate_o == 3'b000, "R1", "gate in reset", int'(gate_o), 0);
    check(gate_n_o == 3'b111, "R1", "gate_n in reset", int'(gate_n_o), 7);
    check(!sync_o, "R1", "sync in reset", int'(sync_o), 0);
    rst_ni = 1'b1;
    // R2 first peak BAND-1 cycles after release, then every PER
    k = 0;
    @(negedge clk);
    k = 1;
    while (!sync_o && k < 100) begin
      @(negedge clk);
      k++;
    end
    check(k == TOP, "R2", "first sync cycle", k, TOP);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!sync_o && k < 100);
    check(k == PER, "R2", "sync period", k, PER);

    // R9 zero-pattern alternation
    apply(2, 0);
    last_z = 0;
    prev = 0;
    eps = 0;
    for (int i = 0; i < 5 * PER; i++) begin
      int s;
      @(negedge clk);
      s = int'(state_o);
      if (s == 0 && prev != 0) begin
        check(int'(gate_o) == 7 - last_z, "R9", "zero pattern flip", int'(gate_o), 7 - last_z);
        last_z = int'(gate_o);
        eps++;
      end else if (s == 0 && prev == 0) begin
        if (int'(gate_o) != last_z)
          check(1'b0, "R9", "zero pattern hold", int'(gate_o), last_z);
      end
      prev = s;
    end
    check(eps >= 4, "R9", "zero entries seen", eps, 4);

    // R3..R8 vector table: R3 plain, R4 drift, R5 clamp, R6 negative
    for (int v = 0; v < NV; v++) begin
      apply(VREF[v], VDRF[v]);
      measure(VREF[v], VDRF[v], 1'b0);
      check_counts(VREF[v], VDRF[v],
                   (VREF[v] < 0) ? "R6" : (VDRF[v] > LIM || VDRF[v] < -LIM) ? "R5" :
                   (VDRF[v] != 0) ? "R4" : "R3");
    end

    // R2 inputs outside the peak have no effect
    apply(12, 2);
    measure(12, 2, 1'b1);
    check_counts(12, 2, "R2");

    // R10 registered output lags: reset asserted mid-run clears
    apply(20, 0);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check(state_o == 0 && gate_o == 3'b000, "R1", "mid-run reset", int'(gate_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(state_o == 0, "R10", "first cycle after reset", int'(state_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule